// File: doc/BRIEF.md
# System Glue Register Block

This block is a small memory-mapped peripheral that boot firmware uses to reach a handful of platform services through one 32-byte register window. The window sits on a simple synchronous bus. Each access carries a select, a write enable, an address, a byte count and write data. Read data comes back one cycle later. The requesting processor's index and the number of active processors are supplied as inputs, so firmware can find out who it is and how many processors are running.

Through the window firmware can do four things. It can request a halt of the platform, carrying an 8-bit exit code. It can raise or drop the level-sensitive external interrupt line of any processor. It can push a character to the console. It can poll the console for an incoming character. The console side is a single byte in each direction. The transmit path has a software-writable ready flag. Reading the receive status samples whether a character is pending and, if so, captures it.

Top module: `sysglue_ctrl`

## Requirements
- R1: Only address bits [4:0] are decoded. Any access at offset + 32*k behaves exactly like the same access at offset.
- R2: After reset all interrupt lines are low and there is no halt or transmit strobe. The transmit status (offset 28) reads 1, the receive status (offset 20, with nothing pending) reads 0, and both data registers (offsets 16 and 24) read 0.
- R3: A write to offset 0 produces a `halt_req` pulse of exactly one cycle, in the cycle after the access. `halt_code` carries write-data bits [7:0].
- R4: A write to offset 8 takes the port number from write-data bits [7:0]. It takes the level from bits [15:8] when the byte count is 2 or more; a 1-byte write uses level 0. A nonzero level raises `irq_lines[port]`, and a zero level lowers it. The line changes in the cycle after the access.
- R5: An interrupt write whose port is not below `cpu_count` (or not below NUM_CPU) changes no line. Every line keeps its last level until its own port is written again.
- R6: Read data appears on `bus_rdata` in the cycle after a read access, with the 8-bit value in bits [7:0] and all higher bits zero. Offsets 0 and 8, and any offset other than 4, 12, 16, 20, 24 and 28, read as 0. `bus_rdata` is 0 in cycles that do not follow a read.
- R7: Offset 4 reads `req_cpu` zero-extended, and offset 12 reads `cpu_count`, both as they are in the access cycle.
- R8: A write to offset 24 produces a one-cycle `con_tx_valid` with `con_tx_char` equal to write-data bits [7:0]. It also sets the transmit status (offset 28) to 1, and offset 24 then reads back the character.
- R9: Software writes to offset 16 (receive data) and offset 28 (transmit status) overwrite the stored byte with write-data bits [7:0].
- R10: A read of offset 20 samples `con_rx_pending` in the access cycle. If a character is pending, `con_rx_take` is high in that cycle, `con_rx_char` is stored as receive data, and the read returns 1. Otherwise the read returns 0 and the receive data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [4:0] decoded |
| bus_nbytes | input | NB_W | Bytes in the access (1 to DATA_W/8) |
| bus_wdata | input | DATA_W | Write data; lowest-addressed byte in [7:0] |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| req_cpu | input | CIDX_W | Index of the processor making the access |
| cpu_count | input | 8 | Number of active processors |
| irq_lines | output | NUM_CPU | Level interrupt, one per processor |
| halt_req | output | 1 | One-cycle halt request |
| halt_code | output | 8 | Exit code accompanying the halt |
| con_rx_pending | input | 1 | Console has a character waiting |
| con_rx_char | input | 8 | Waiting console character |
| con_rx_take | output | 1 | Character consumed this cycle |
| con_tx_valid | output | 1 | One-cycle transmit strobe |
| con_tx_char | output | 8 | Transmitted character |

## Verification
The bound checker watches five properties on every cycle. A halt or transmit strobe must trace back to a write at the matching offset in the previous cycle, with the same byte. Interrupt lines may change only after an interrupt write, and at most one line may change per cycle. The upper read-data bits must always be zero. The bench's scenarios cover the rest, because those properties depend on stored values or computed decode: the full 256-address read sweep against an arithmetic model, the interrupt port/level sweep with ports above the processor count, the 1-byte level-zero case, the software overwrite of the console registers, and the receive-status sampling with and without a pending character.

// File: rtl/sysglue_pkg.sv
`timescale 1ns/1ps
package sysglue_pkg;

   localparam int OFF_W = 5;

   // Offsets inside the 32-byte window
   localparam logic [OFF_W-1:0] OFF_HALT  = 5'd0;
   localparam logic [OFF_W-1:0] OFF_CPUID = 5'd4;
   localparam logic [OFF_W-1:0] OFF_IRQ   = 5'd8;
   localparam logic [OFF_W-1:0] OFF_NCPU  = 5'd12;
   localparam logic [OFF_W-1:0] OFF_RXD   = 5'd16;
   localparam logic [OFF_W-1:0] OFF_RXS   = 5'd20;
   localparam logic [OFF_W-1:0] OFF_TXD   = 5'd24;
   localparam logic [OFF_W-1:0] OFF_TXS   = 5'd28;

   typedef struct packed {
      logic halt_wr;
      logic irq_wr;
      logic rxd_wr;
      logic rxs_wr;
      logic txd_wr;
      logic txs_wr;
      logic cpuid_rd;
      logic ncpu_rd;
      logic rxd_rd;
      logic rxs_rd;
      logic txd_rd;
      logic txs_rd;
      logic any_rd;
   } glue_sel_t;

endpackage

// File: rtl/sysglue_decode.sv
`timescale 1ns/1ps
module sysglue_decode
   import sysglue_pkg::*;
(
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [OFF_W-1:0] acc_off,
   output glue_sel_t        sel
);
   logic wr;
   logic rd;

   assign wr = acc_valid & acc_write;
   assign rd = acc_valid & ~acc_write;

   always_comb begin
      sel          = '0;
      sel.any_rd   = rd;
      sel.halt_wr  = wr & (acc_off == OFF_HALT);
      sel.irq_wr   = wr & (acc_off == OFF_IRQ);
      sel.rxd_wr   = wr & (acc_off == OFF_RXD);
      sel.rxs_wr   = wr & (acc_off == OFF_RXS);
      sel.txd_wr   = wr & (acc_off == OFF_TXD);
      sel.txs_wr   = wr & (acc_off == OFF_TXS);
      sel.cpuid_rd = rd & (acc_off == OFF_CPUID);
      sel.ncpu_rd  = rd & (acc_off == OFF_NCPU);
      sel.rxd_rd   = rd & (acc_off == OFF_RXD);
      sel.rxs_rd   = rd & (acc_off == OFF_RXS);
      sel.txd_rd   = rd & (acc_off == OFF_TXD);
      sel.txs_rd   = rd & (acc_off == OFF_TXS);
   end
endmodule

// File: rtl/sysglue_irq_bank.sv
`timescale 1ns/1ps
module sysglue_irq_bank #(
   parameter int NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [7:0]         port,
   input  logic [7:0]         level,
   input  logic [7:0]         active_cnt,
   output logic [NUM_CPU-1:0] lines
);
   logic level_on;
   assign level_on = |level;

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_line
      localparam logic [7:0] IDX = 8'(g);
      logic hit;
      // R5: a port at or above the active count is ignored
      assign hit = set_en && (port == IDX) && (IDX < active_cnt);

      always_ff @(posedge clk) begin
         if (!rst_n)   lines[g] <= 1'b0;
         else if (hit) lines[g] <= level_on;   // R4
      end
   end
endmodule

// File: rtl/sysglue_console.sv
`timescale 1ns/1ps
module sysglue_console
   import sysglue_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  glue_sel_t  sel,
   input  logic [7:0] wbyte,
   input  logic       rx_pending,
   input  logic [7:0] rx_char,
   output logic       rx_take,
   output logic [7:0] rx_sample,
   output logic [7:0] rx_data,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic [7:0] tx_stat
);
   // R10: status read samples the console input in the access cycle
   assign rx_take   = sel.rxs_rd & rx_pending;
   assign rx_sample = {7'd0, rx_pending};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_data  <= 8'd0;
         tx_data  <= 8'd0;
         tx_stat  <= 8'd1;
         tx_valid <= 1'b0;
      end else begin
         tx_valid <= sel.txd_wr;                       // R8
         if (rx_take)         rx_data <= rx_char;      // R10
         else if (sel.rxd_wr) rx_data <= wbyte;        // R9
         if (sel.txd_wr) begin
            tx_data <= wbyte;
            tx_stat <= 8'd1;
         end else if (sel.txs_wr) begin
            tx_stat <= wbyte;                          // R9
         end
      end
   end
endmodule

// File: rtl/sysglue_ctrl.sv
`timescale 1ns/1ps
module sysglue_ctrl
   import sysglue_pkg::*;
#(
   parameter int NUM_CPU  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b1,
   localparam int NB_W    = $clog2(DATA_W / 8) + 1,
   localparam int CIDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [NB_W-1:0]    bus_nbytes,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [CIDX_W-1:0]  req_cpu,
   input  logic [7:0]         cpu_count,
   output logic [NUM_CPU-1:0] irq_lines,
   output logic               halt_req,
   output logic [7:0]         halt_code,
   input  logic               con_rx_pending,
   input  logic [7:0]         con_rx_char,
   output logic               con_rx_take,
   output logic               con_tx_valid,
   output logic [7:0]         con_tx_char
);
   // Elaboration-time parameter checks
   if (NUM_CPU < 1 || NUM_CPU > 256) begin : g_bad_cpu
      $error("sysglue_ctrl: NUM_CPU must be 1..256");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("sysglue_ctrl: ADDR_W must cover the 32-byte window");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("sysglue_ctrl: DATA_W must be a multiple of 8, at least 16");
   end

   localparam int RD_PAD = DATA_W - 8;

   glue_sel_t  sel;
   logic [7:0] wbyte0;
   logic [7:0] wbyte1;
   logic [7:0] irq_level;
   logic [7:0] rx_sample;
   logic [7:0] rx_data;
   logic [7:0] tx_data;
   logic [7:0] tx_stat;
   logic [7:0] rd_byte;
   logic [DATA_W-1:0] rd_word;

   assign wbyte0 = bus_wdata[7:0];
   assign wbyte1 = bus_wdata[15:8];

   // R1: only the low five address bits reach the decoder
   sysglue_decode u_dec (
      .acc_valid (bus_sel),
      .acc_write (bus_we),
      .acc_off   (bus_addr[OFF_W-1:0]),
      .sel       (sel)
   );

   if (ADDR_W > OFF_W) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];
   end
   if (DATA_W > 16) begin : g_data_hi
      logic unused_data_hi;
      assign unused_data_hi = ^bus_wdata[DATA_W-1:16];
   end

   // R4: the level byte exists only in writes of two or more bytes
   assign irq_level = (bus_nbytes > NB_W'(1)) ? wbyte1 : 8'd0;

   sysglue_irq_bank #(.NUM_CPU(NUM_CPU)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (sel.irq_wr),
      .port       (wbyte0),
      .level      (irq_level),
      .active_cnt (cpu_count),
      .lines      (irq_lines)
   );

   sysglue_console u_con (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .wbyte      (wbyte0),
      .rx_pending (con_rx_pending),
      .rx_char    (con_rx_char),
      .rx_take    (con_rx_take),
      .rx_sample  (rx_sample),
      .rx_data    (rx_data),
      .tx_valid   (con_tx_valid),
      .tx_data    (tx_data),
      .tx_stat    (tx_stat)
   );
   assign con_tx_char = tx_data;

   // R3: halt pulse with exit code
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_req  <= 1'b0;
         halt_code <= 8'd0;
      end else begin
         halt_req <= sel.halt_wr;
         if (sel.halt_wr) halt_code <= wbyte0;
      end
   end

   // R6/R7: read byte select, everything else reads zero
   always_comb begin
      rd_byte = 8'd0;
      if (sel.cpuid_rd)     rd_byte = 8'(req_cpu);
      else if (sel.ncpu_rd) rd_byte = cpu_count;
      else if (sel.rxd_rd)  rd_byte = rx_data;
      else if (sel.rxs_rd)  rd_byte = rx_sample;
      else if (sel.txd_rd)  rd_byte = tx_data;
      else if (sel.txs_rd)  rd_byte = tx_stat;
   end
   assign rd_word = sel.any_rd ? {{RD_PAD{1'b0}}, rd_byte} : '0;

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_word;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_word;
   end
endmodule

// File: rtl/sysglue_ctrl_chk.sv
`timescale 1ns/1ps
module sysglue_ctrl_chk #(
   parameter int NUM_CPU  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   localparam int NB_W    = $clog2(DATA_W / 8) + 1,
   localparam int CIDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_CPU-1:0] irq_lines,
   input logic               halt_req,
   input logic [7:0]         halt_code,
   input logic               con_tx_valid,
   input logic [7:0]         con_tx_char
);
   assert_halt_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(bus_sel && bus_we && bus_addr[4:0] == 5'd0));

   assert_halt_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> (halt_code == $past(bus_wdata[7:0])));

   assert_tx_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      con_tx_valid |-> ($past(bus_sel && bus_we && bus_addr[4:0] == 5'd24)
                        && con_tx_char == $past(bus_wdata[7:0])));

   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we && bus_addr[4:0] == 5'd8) |=> $stable(irq_lines));

   assert_irq_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_lines ^ $past(irq_lines)) <= 1);

   assert_rdata_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:8] == '0);
endmodule

bind sysglue_ctrl sysglue_ctrl_chk #(
   .NUM_CPU (NUM_CPU),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .irq_lines    (irq_lines),
   .halt_req     (halt_req),
   .halt_code    (halt_code),
   .con_tx_valid (con_tx_valid),
   .con_tx_char  (con_tx_char)
);

// File: tb/sysglue_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysglue_ctrl_tb_top;
   localparam int NUM_CPU = 4;
   localparam int ADDR_W  = 8;
   localparam int DATA_W  = 32;
   localparam int NB_W    = 3;
   localparam int CIDX_W  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic               bus_sel = 1'b0;
   logic               bus_we = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic [NB_W-1:0]    bus_nbytes = 3'd4;
   logic [DATA_W-1:0]  bus_wdata = '0;
   logic [DATA_W-1:0]  bus_rdata;
   logic [CIDX_W-1:0]  req_cpu = '0;
   logic [7:0]         cpu_count = 8'd3;
   logic [NUM_CPU-1:0] irq_lines;
   logic               halt_req;
   logic [7:0]         halt_code;
   logic               con_rx_pending = 1'b0;
   logic [7:0]         con_rx_char = 8'd0;
   logic               con_rx_take;
   logic               con_tx_valid;
   logic [7:0]         con_tx_char;

   sysglue_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .req_cpu(req_cpu), .cpu_count(cpu_count),
      .irq_lines(irq_lines), .halt_req(halt_req), .halt_code(halt_code),
      .con_rx_pending(con_rx_pending), .con_rx_char(con_rx_char),
      .con_rx_take(con_rx_take), .con_tx_valid(con_tx_valid),
      .con_tx_char(con_tx_char)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model of the stored state
   logic [7:0]         m_rxd = 8'd0;
   logic [7:0]         m_txd = 8'd0;
   logic [7:0]         m_txs = 8'd1;
   logic [NUM_CPU-1:0] m_irq = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [2:0] nb, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_nbytes = nb; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_nbytes = 3'd4;
      @(negedge clk);
      bus_sel = 1'b0;
      check(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   function automatic logic [31:0] model_rd(input logic [4:0] off);
      case (off)
         5'd4:    return 32'(req_cpu);
         5'd12:   return 32'(cpu_count);
         5'd16:   return 32'(m_rxd);
         5'd20:   return 32'(con_rx_pending);
         5'd24:   return 32'(m_txd);
         5'd28:   return 32'(m_txs);
         default: return 32'd0;
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      check(irq_lines === '0, "R2 irq", 32'(irq_lines), 32'd0);
      check(halt_req === 1'b0, "R2 halt", 32'(halt_req), 32'd0);
      check(con_tx_valid === 1'b0, "R2 tx strobe", 32'(con_tx_valid), 32'd0);
      check(bus_rdata === '0, "R6 idle rdata", bus_rdata, 32'd0);
      rd(8'd16, 32'd0, "R2 rx data");
      rd(8'd24, 32'd0, "R2 tx data");
      rd(8'd28, 32'd1, "R2 tx status");
      rd(8'd20, 32'd0, "R2 rx status");

      // R7: identity and count
      for (int c = 0; c < NUM_CPU; c++) begin
         req_cpu = CIDX_W'(c);
         rd(8'd4, 32'(c), "R7 cpu index");
      end
      foreach (cpu_count[i]) begin
         cpu_count = 8'(1 << i);
         rd(8'd12, 32'(1 << i), "R7 cpu count");
      end
      cpu_count = 8'd3;
      req_cpu = 2'd2;

      // R1/R6: full address sweep
      for (int a = 0; a < 256; a++) begin
         rd(8'(a), model_rd(5'(a)), (a < 32) ? "R6 decode" : "R1 alias");
      end

      // R9: software overwrite
      wr(8'd16, 3'd1, 32'h0000_0077); m_rxd = 8'h77;
      rd(8'd16, 32'h77, "R9 rx data write");
      wr(8'd28, 3'd4, 32'hFFFF_FF00); m_txs = 8'h00;
      rd(8'd28, 32'h00, "R9 tx status write");

      // R8: transmit
      wr(8'd24, 3'd4, 32'hABCD_EF41); m_txd = 8'h41; m_txs = 8'd1;
      check(con_tx_valid === 1'b1 && con_tx_char === 8'h41, "R8 tx strobe",
            {con_tx_valid, con_tx_char}, {1'b1, 8'h41});
      @(negedge clk);
      check(con_tx_valid === 1'b0, "R8 tx single pulse", 32'(con_tx_valid), 32'd0);
      rd(8'd28, 32'd1, "R8 tx status set");
      rd(8'd24, 32'h41, "R8 tx readback");
      wr(8'd56, 3'd1, 32'h0000_005A); m_txd = 8'h5A;
      check(con_tx_valid === 1'b1 && con_tx_char === 8'h5A, "R1 tx alias",
            {con_tx_valid, con_tx_char}, {1'b1, 8'h5A});

      // R10: receive sampling
      con_rx_pending = 1'b1; con_rx_char = 8'h9C;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'd20;
      #1;
      check(con_rx_take === 1'b1, "R10 take pulse", 32'(con_rx_take), 32'd1);
      @(negedge clk);
      bus_sel = 1'b0; m_rxd = 8'h9C;
      check(bus_rdata === 32'd1, "R10 status pending", bus_rdata, 32'd1);
      con_rx_pending = 1'b0; con_rx_char = 8'h11;
      #1;
      check(con_rx_take === 1'b0, "R10 no take when idle", 32'(con_rx_take), 32'd0);
      rd(8'd16, 32'h9C, "R10 latched char");
      rd(8'd20, 32'd0, "R10 status empty");
      rd(8'd16, 32'h9C, "R10 data kept");

      // R3: halt
      wr(8'd0, 3'd4, 32'h1234_56A5);
      check(halt_req === 1'b1 && halt_code === 8'hA5, "R3 halt pulse",
            {halt_req, halt_code}, {1'b1, 8'hA5});
      @(negedge clk);
      check(halt_req === 1'b0, "R3 halt single", 32'(halt_req), 32'd0);
      wr(8'h60, 3'd1, 32'h0000_0003);
      check(halt_req === 1'b1 && halt_code === 8'h03, "R1 halt alias",
            {halt_req, halt_code}, {1'b1, 8'h03});

      // R4/R5: interrupt sweep with three active processors
      for (int p = 0; p < 6; p++) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] lvl;
            lvl = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : (k == 2) ? 8'h00 : 8'h7F;
            wr(8'd8, 3'd2, {16'd0, lvl, 8'(p)});
            if (p < 3) m_irq[p] = (lvl != 8'd0);
            check(irq_lines === m_irq, (p < 3) ? "R4 port level" : "R5 port ignored",
                  32'(irq_lines), 32'(m_irq));
         end
      end
      wr(8'd8, 3'd1, 32'h0000_FF01); m_irq[1] = 1'b0;
      check(irq_lines === m_irq, "R4 single byte level zero", 32'(irq_lines), 32'(m_irq));
      wr(8'd8, 3'd2, 32'h0000_01C8);
      check(irq_lines === m_irq, "R5 port far out of range", 32'(irq_lines), 32'(m_irq));
      repeat (4) @(negedge clk);
      check(irq_lines === m_irq, "R5 lines hold", 32'(irq_lines), 32'(m_irq));
      cpu_count = 8'd4;
      wr(8'd40, 3'd4, 32'h0000_0103); m_irq[3] = 1'b1;
      check(irq_lines === m_irq, "R1 irq alias", 32'(irq_lines), 32'(m_irq));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule